// File: doc/BRIEF.md
# Register-Mapped Byte-Stream Network Controller

This block connects a simple 32-bit host read/write bus to two byte streams, one for incoming frames and one for outgoing frames. An incoming frame arrives on a valid/ready stream with an end-of-frame marker and is captured into a local buffer. The controller then publishes the byte count and raises a receive interrupt. The host drains the frame through a one-byte data port. Each read of that port returns the next byte and lowers the published count by one.

To send, the host writes a byte count and then pushes that many bytes through a second one-byte data port. Once the final byte has been written, the controller clears the count and streams the bytes out on a valid/ready stream, marking the final byte. The register window also holds a fixed identifier string, a busy flag and an interrupt control word. Two interrupt sources are cleared by writing one to them, and a self-test interrupt clears when it is read.

Reads return data on the cycle after the request. `bus_rvalid` marks that cycle.

Top module: `bytenet_ctrl`

## Requirements
- R1: Offsets 0x00 and 0x04 read the identifier string "BSNETIF1", with its first character in the least significant byte. This gives 0x454E5342 at 0x00 and 0x31464954 at 0x04.
- R2: After reset, busy (0x08), receive count (0x0C), transmit count (0x10), interrupt control (0x14) and irq all read zero. Interrupt info (0x18), the transmit data port (0x20) and every unused offset in the 0x40-byte window always read zero.
- R3: Accepting the byte marked last loads the receive count (0x0C) with the frame length, sets interrupt control bit 1 and raises irq.
- R4: Each read of the receive data port (0x1C) while the count is non-zero returns the next byte in arrival order in bits 7:0 and lowers the count by one. When the count is zero, the port reads zero.
- R5: rx_ready is low while the receive count is non-zero or interrupt control bit 1 is set. It stays low after the frame has been drained, until bit 1 is cleared.
- R6: A frame longer than DEPTH bytes keeps only its first DEPTH bytes, and the receive count reads DEPTH.
- R7: A count written to 0x10 while no transmit is in progress reads back until the final data byte is written, and then reads zero. Values above DEPTH are clamped to DEPTH.
- R8: No byte leaves before the final data byte is written. The bytes then leave in write order, holding steady while tx_ready is low, and tx_last is high only on the final byte.
- R9: Interrupt control bit 0 sets when the final transmit byte is accepted, and not earlier.
- R10: The busy register (0x08) reads 1 while a receive frame is partly captured or a transmit is pending or streaming.
- R11: Writing a value with bit 31 set to 0x14 raises the test interrupt and irq. A read of 0x14 returns the bit and then clears it, and a write of zero also clears it.
- R12: Writing 1 to bit 0 or bit 1 of 0x14 clears only that bit. irq is the OR of bits 0, 1 and 31.
- R13: Writes to the transmit data port while the transmit count is zero, and writes of zero to the transmit count, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Host access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset within the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the request |
| bus_rvalid | output | 1 | Marks the cycle in which bus_rdata holds read data |
| rx_valid | input | 1 | Incoming byte valid |
| rx_data | input | 8 | Incoming byte |
| rx_last | input | 1 | Incoming byte ends the frame |
| rx_ready | output | 1 | Controller accepts an incoming byte |
| tx_valid | output | 1 | Outgoing byte valid |
| tx_data | output | 8 | Outgoing byte |
| tx_last | output | 1 | Outgoing byte ends the frame |
| tx_ready | input | 1 | Sink accepts the outgoing byte |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a drained receive buffer whose interrupt bit is still set. The count reads zero, yet the controller must keep refusing input. The bench reaches it by draining every byte and sampling rx_ready before it writes the clear. It then sets both interrupt bits at once by finishing a transmit and a receive before clearing either bit, which shows that each clear leaves the other bit untouched. Transmit backpressure follows a repeating ready pattern, so tx_data is observed while it must hold steady.

// File: rtl/bytenet_pkg.sv
package bytenet_pkg;
    localparam int ADDR_W = 6;

    localparam logic [ADDR_W-1:0] OFF_ID_LO = 6'h00;
    localparam logic [ADDR_W-1:0] OFF_ID_HI = 6'h04;
    localparam logic [ADDR_W-1:0] OFF_BUSY  = 6'h08;
    localparam logic [ADDR_W-1:0] OFF_RXCNT = 6'h0C;
    localparam logic [ADDR_W-1:0] OFF_TXCNT = 6'h10;
    localparam logic [ADDR_W-1:0] OFF_ICTL  = 6'h14;
    localparam logic [ADDR_W-1:0] OFF_RXDAT = 6'h1C;
    localparam logic [ADDR_W-1:0] OFF_TXDAT = 6'h20;

    // First character in the least significant byte, version digit last.
    localparam logic [63:0] DEV_ID = "1FITENSB";

    localparam int BIT_TXDONE = 0;
    localparam int BIT_RXAVL  = 1;
    localparam int BIT_TEST   = 31;
endpackage

// File: rtl/bytenet_rx.sv
module bytenet_rx #(
    parameter int DEPTH = 32,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_last,
    output logic             in_ready,
    input  logic             hold,
    input  logic             pop,
    output logic [CNT_W-1:0] cnt,
    output logic [7:0]       head_byte,
    output logic             frame_done,
    output logic             in_frame
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] ONE_C   = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] fill;
        logic [CNT_W-1:0] cnt;
        logic [AW-1:0]    rptr;
        logic             infr;
    } rx_state_t;

    rx_state_t q, d;
    logic [7:0] mem_q [DEPTH];
    logic       mem_we;
    logic       accept;
    logic       pending;

    assign pending  = (q.cnt != '0);
    assign in_ready = !pending && !hold;
    assign accept   = in_valid && in_ready;

    always_comb begin
        d          = q;
        frame_done = 1'b0;
        mem_we     = 1'b0;
        if (accept) begin
            if (q.fill < DEPTH_C) begin
                mem_we = 1'b1;
            end
            if (in_last) begin
                d.cnt      = (q.fill < DEPTH_C) ? q.fill + ONE_C : q.fill;
                d.fill     = '0;
                d.rptr     = '0;
                d.infr     = 1'b0;
                frame_done = 1'b1;
            end else begin
                d.fill = (q.fill < DEPTH_C) ? q.fill + ONE_C : q.fill;
                d.infr = 1'b1;
            end
        end
        if (pop && pending) begin
            d.cnt  = q.cnt - ONE_C;
            d.rptr = q.rptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_ff @(posedge clk) begin
        if (mem_we) begin
            mem_q[q.fill[AW-1:0]] <= in_data;
        end
    end

    assign cnt       = q.cnt;
    assign head_byte = mem_q[q.rptr];
    assign in_frame  = q.infr;

    // R6
    rx_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= DEPTH_C);
    // R3
    rx_load_on_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_last) |=> (q.cnt != '0));
    // R4
    rx_pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && q.cnt != '0) |=> (q.cnt == $past(q.cnt) - ONE_C));
endmodule

// File: rtl/bytenet_tx.sv
module bytenet_tx #(
    parameter int DEPTH = 32,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             len_we,
    input  logic [31:0]      len_wdata,
    input  logic             dat_we,
    input  logic [7:0]       dat_wdata,
    output logic [CNT_W-1:0] len,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic             out_last,
    input  logic             out_ready,
    output logic             sent,
    output logic             active
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] ONE_C   = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] len;
        logic [CNT_W-1:0] wcnt;
        logic [CNT_W-1:0] total;
        logic [CNT_W-1:0] rptr;
        logic             stream;
    } tx_state_t;

    tx_state_t q, d;
    logic [7:0] mem_q [DEPTH];
    logic       mem_we;
    logic       idle;

    assign idle     = (q.len == '0) && !q.stream;
    assign out_valid = q.stream;
    assign out_data  = mem_q[q.rptr[AW-1:0]];
    assign out_last  = q.stream && (q.rptr + ONE_C == q.total);

    always_comb begin
        d      = q;
        sent   = 1'b0;
        mem_we = 1'b0;
        if (len_we && idle && len_wdata != 32'd0) begin
            d.len  = (len_wdata > 32'(DEPTH)) ? DEPTH_C : len_wdata[CNT_W-1:0];
            d.wcnt = '0;
        end else if (dat_we && q.len != '0) begin
            mem_we = 1'b1;
            d.wcnt = q.wcnt + ONE_C;
            if (q.wcnt + ONE_C == q.len) begin
                d.total  = q.len;
                d.len    = '0;
                d.stream = 1'b1;
                d.rptr   = '0;
            end
        end
        if (q.stream && out_ready) begin
            if (out_last) begin
                d.stream = 1'b0;
                sent     = 1'b1;
            end else begin
                d.rptr = q.rptr + ONE_C;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_ff @(posedge clk) begin
        if (mem_we) begin
            mem_q[q.wcnt[AW-1:0]] <= dat_wdata;
        end
    end

    assign len    = q.len;
    assign active = !idle;

    // R8
    tx_hold_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
    // R7
    tx_len_vs_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.len != '0) |-> !q.stream);
    // R9
    tx_sent_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sent |=> !out_valid);
endmodule

// File: rtl/bytenet_irq.sv
module bytenet_irq (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        set_tx,
    input  logic        set_rx,
    input  logic        ctl_we,
    input  logic [31:0] ctl_wdata,
    input  logic        ctl_rd,
    output logic [31:0] ctl_val,
    output logic        irq
);
    import bytenet_pkg::*;

    typedef struct packed {
        logic txd;
        logic rxd;
        logic tst;
    } irq_state_t;

    irq_state_t q, d;

    always_comb begin
        d = q;
        if (ctl_we) begin
            if (ctl_wdata == 32'd0) begin
                d.tst = 1'b0;
            end else begin
                if (ctl_wdata[BIT_TXDONE]) d.txd = 1'b0;
                if (ctl_wdata[BIT_RXAVL])  d.rxd = 1'b0;
                if (ctl_wdata[BIT_TEST])   d.tst = 1'b1;
            end
        end
        if (ctl_rd) begin
            d.tst = 1'b0;
        end
        if (set_tx) d.txd = 1'b1;
        if (set_rx) d.rxd = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        ctl_val             = '0;
        ctl_val[BIT_TXDONE] = q.txd;
        ctl_val[BIT_RXAVL]  = q.rxd;
        ctl_val[BIT_TEST]   = q.tst;
    end

    assign irq = q.txd | q.rxd | q.tst;

    // R3
    irq_rx_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_rx |=> q.rxd);
    // R11
    irq_test_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rd && !ctl_we) |=> !q.tst);
    // R9
    irq_tx_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_tx |=> q.txd);
endmodule

// File: rtl/bytenet_ctrl.sv
module bytenet_ctrl #(
    parameter int DEPTH = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [5:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        bus_rvalid,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    input  logic        rx_last,
    output logic        rx_ready,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    output logic        tx_last,
    input  logic        tx_ready,
    output logic        irq
);
    import bytenet_pkg::*;

    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [31:0] rdata;
        logic        rvalid;
    } rd_state_t;

    rd_state_t q, d;

    logic             rd_en, wr_en;
    logic [CNT_W-1:0] rx_cnt, tx_len;
    logic [7:0]       rx_head;
    logic             rx_done, rx_infr, tx_sent, tx_active;
    logic [31:0]      ictl_val;
    logic             busy;

    assign rd_en = bus_sel && !bus_wr;
    assign wr_en = bus_sel && bus_wr;

    bytenet_irq u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_tx    (tx_sent),
        .set_rx    (rx_done),
        .ctl_we    (wr_en && bus_addr == OFF_ICTL),
        .ctl_wdata (bus_wdata),
        .ctl_rd    (rd_en && bus_addr == OFF_ICTL),
        .ctl_val   (ictl_val),
        .irq       (irq)
    );

    bytenet_rx #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (rx_valid),
        .in_data    (rx_data),
        .in_last    (rx_last),
        .in_ready   (rx_ready),
        .hold       (ictl_val[BIT_RXAVL]),
        .pop        (rd_en && bus_addr == OFF_RXDAT),
        .cnt        (rx_cnt),
        .head_byte  (rx_head),
        .frame_done (rx_done),
        .in_frame   (rx_infr)
    );

    bytenet_tx #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .len_we    (wr_en && bus_addr == OFF_TXCNT),
        .len_wdata (bus_wdata),
        .dat_we    (wr_en && bus_addr == OFF_TXDAT),
        .dat_wdata (bus_wdata[7:0]),
        .len       (tx_len),
        .out_valid (tx_valid),
        .out_data  (tx_data),
        .out_last  (tx_last),
        .out_ready (tx_ready),
        .sent      (tx_sent),
        .active    (tx_active)
    );

    assign busy = rx_infr || tx_active;

    always_comb begin
        d        = q;
        d.rvalid = rd_en;
        if (rd_en) begin
            case (bus_addr)
                OFF_ID_LO: d.rdata = DEV_ID[31:0];
                OFF_ID_HI: d.rdata = DEV_ID[63:32];
                OFF_BUSY:  d.rdata = {31'd0, busy};
                OFF_RXCNT: d.rdata = 32'(rx_cnt);
                OFF_TXCNT: d.rdata = 32'(tx_len);
                OFF_ICTL:  d.rdata = ictl_val;
                OFF_RXDAT: d.rdata = (rx_cnt != '0) ? {24'd0, rx_head} : 32'd0;
                default:   d.rdata = 32'd0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign bus_rdata  = q.rdata;
    assign bus_rvalid = q.rvalid;

    // R5
    rx_refuse_when_flagged_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ictl_val[BIT_RXAVL] |-> !rx_ready);
    // R12
    irq_matches_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (ictl_val[BIT_TXDONE] | ictl_val[BIT_RXAVL] | ictl_val[BIT_TEST]));
endmodule

// File: tb/tb_bytenet_ctrl.sv
module tb_bytenet_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic        rx_valid = 1'b0, rx_last = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_ready;
    logic        tx_valid, tx_last;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b0;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    bytenet_ctrl #(.DEPTH(DEPTH)) dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct packed {
        logic [5:0]  a;
        logic [31:0] e;
    } vec_t;

    // R1 / R2: register reads straight after reset
    localparam vec_t RST_TBL [10] = '{
        '{6'h00, 32'h454E5342}, '{6'h04, 32'h31464954},
        '{6'h08, 32'h0}, '{6'h0C, 32'h0}, '{6'h10, 32'h0},
        '{6'h14, 32'h0}, '{6'h18, 32'h0}, '{6'h20, 32'h0},
        '{6'h3C, 32'h0}, '{6'h02, 32'h0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic bwrite(input logic [5:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bread(input logic [5:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        v = bus_rdata;
    endtask

    task automatic rx_push(input logic [7:0] b, input logic l);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = b; rx_last = l;
        while (!rx_ready) @(negedge clk);
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0;
    endtask

    logic [7:0] got_d [DEPTH];
    logic       got_l [DEPTH];

    task automatic tx_drain(input int n);
        int got = 0;
        int k = 0;
        while (got < n) begin
            @(negedge clk);
            tx_ready = ((k % 3) != 1);
            k++;
            if (tx_valid && tx_ready) begin
                got_d[got] = tx_data;
                got_l[got] = tx_last;
                got++;
            end
        end
        @(negedge clk);
        tx_ready = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 R2: table walk
        for (int i = 0; i < 10; i++) begin
            bread(RST_TBL[i].a, v);
            chk($sformatf("R1/R2 addr 0x%02h", RST_TBL[i].a), v, RST_TBL[i].e);
        end
        chk("R2 irq idle", {31'd0, irq}, 32'd0);
        chk("R2 rx_ready idle", {31'd0, rx_ready}, 32'd1);
        chk("R2 tx_valid idle", {31'd0, tx_valid}, 32'd0);

        // R10: busy mid-frame
        rx_push(8'hA0, 1'b0);
        rx_push(8'hA1, 1'b0);
        bread(6'h08, v); chk("R10 busy during rx", v, 32'd1);
        rx_push(8'hA2, 1'b0);
        rx_push(8'hA3, 1'b0);
        rx_push(8'hA4, 1'b1);
        // R3
        bread(6'h0C, v); chk("R3 rx count", v, 32'd5);
        bread(6'h14, v); chk("R3 rx bit", v, 32'h2);
        chk("R3 irq", {31'd0, irq}, 32'd1);
        chk("R5 ready low pending", {31'd0, rx_ready}, 32'd0);
        bread(6'h08, v); chk("R10 busy clear after rx", v, 32'd0);
        // R4
        bread(6'h1C, v); chk("R4 byte0", v, 32'hA0);
        bread(6'h1C, v); chk("R4 byte1", v, 32'hA1);
        bread(6'h0C, v); chk("R4 count after two", v, 32'd3);
        bread(6'h1C, v); chk("R4 byte2", v, 32'hA2);
        bread(6'h1C, v); chk("R4 byte3", v, 32'hA3);
        bread(6'h1C, v); chk("R4 byte4", v, 32'hA4);
        bread(6'h0C, v); chk("R4 count drained", v, 32'd0);
        bread(6'h1C, v); chk("R4 empty port", v, 32'd0);
        // R5: still refused until cleared
        chk("R5 ready low flagged", {31'd0, rx_ready}, 32'd0);
        bwrite(6'h14, 32'h2);
        bread(6'h14, v); chk("R12 rx bit cleared", v, 32'd0);
        chk("R5 ready back", {31'd0, rx_ready}, 32'd1);
        chk("R12 irq low", {31'd0, irq}, 32'd0);

        // R6: oversize frame
        for (int i = 0; i < DEPTH + 3; i++) rx_push(8'(i + 16), i == DEPTH + 2);
        bread(6'h0C, v); chk("R6 clamped count", v, DEPTH);
        for (int i = 0; i < DEPTH; i++) begin
            bread(6'h1C, v);
            if (i == 0 || i == DEPTH - 1) chk("R6 kept byte", v, 32'(i + 16));
        end
        bwrite(6'h14, 32'h2);

        // R13: ignored writes
        bwrite(6'h20, 32'h55);
        bwrite(6'h10, 32'h0);
        bread(6'h10, v); chk("R13 tx count stays zero", v, 32'd0);
        repeat (2) @(negedge clk);
        chk("R13 no output", {31'd0, tx_valid}, 32'd0);
        bread(6'h08, v); chk("R13 not busy", v, 32'd0);

        // R7 R8 R9: transmit of four bytes
        bwrite(6'h10, 32'd4);
        bread(6'h10, v); chk("R7 count readback", v, 32'd4);
        bwrite(6'h20, 32'hFFFF_FF11);
        bwrite(6'h20, 32'h22);
        bwrite(6'h20, 32'h33);
        bread(6'h10, v); chk("R7 count held", v, 32'd4);
        chk("R8 nothing before final", {31'd0, tx_valid}, 32'd0);
        bwrite(6'h20, 32'h44);
        bread(6'h10, v); chk("R7 count cleared", v, 32'd0);
        chk("R8 valid after final", {31'd0, tx_valid}, 32'd1);
        bread(6'h08, v); chk("R10 busy during tx", v, 32'd1);
        repeat (3) @(negedge clk);
        chk("R8 held under backpressure", {24'd0, tx_data}, 32'h11);
        bread(6'h14, v); chk("R9 not yet done", v, 32'd0);
        tx_drain(4);
        for (int i = 0; i < 4; i++) begin
            chk($sformatf("R8 data %0d", i), {24'd0, got_d[i]}, 32'(8'h11 * (i + 1)));
            chk($sformatf("R8 last %0d", i), {31'd0, got_l[i]}, 32'(i == 3));
        end
        bread(6'h14, v); chk("R9 done bit", v, 32'h1);
        // R12: both set, clear one
        rx_push(8'h77, 1'b1);
        bread(6'h14, v); chk("R12 both bits", v, 32'h3);
        bwrite(6'h14, 32'h1);
        bread(6'h14, v); chk("R12 only tx cleared", v, 32'h2);
        bread(6'h1C, v); chk("R4 single byte", v, 32'h77);
        bwrite(6'h14, 32'h2);
        chk("R12 irq low again", {31'd0, irq}, 32'd0);

        // R7: clamp
        bwrite(6'h10, DEPTH + 10);
        bread(6'h10, v); chk("R7 clamp", v, DEPTH);
        for (int i = 0; i < DEPTH; i++) bwrite(6'h20, 32'(i + 1));
        tx_drain(DEPTH);
        chk("R7 clamp final byte", {24'd0, got_d[DEPTH-1]}, DEPTH);
        chk("R8 clamp last flag", {31'd0, got_l[DEPTH-1]}, 32'd1);
        bwrite(6'h14, 32'h1);

        // R11: test interrupt
        bwrite(6'h14, 32'h8000_0000);
        chk("R11 irq raised", {31'd0, irq}, 32'd1);
        bread(6'h14, v); chk("R11 read shows test", v, 32'h8000_0000);
        bread(6'h14, v); chk("R11 cleared by read", v, 32'd0);
        chk("R11 irq dropped", {31'd0, irq}, 32'd0);
        bwrite(6'h14, 32'h8000_0000);
        bwrite(6'h14, 32'h0);
        bread(6'h14, v); chk("R11 cleared by zero write", v, 32'd0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule